// File: doc/BRIEF.md
# Radix-2 FFT Stage Sequencer

This block runs one stage of a pipelined radix-2 decimation-in-frequency FFT. It owns the stage's working memory, takes a frame of N complex samples, and feeds pairs of samples to an external butterfly unit one pair per cycle. It also presents the twiddle-table address for each pair and writes the two butterfly results back into the words the operands came from. Each memory word holds one complex sample, with the real part in the upper half and the imaginary part in the lower half. A splitting buffer turns the two words read into four real operands. A joining buffer packs the four real results back into two words.

The stage index and the transform size are parameters. A chain of log2(N) instances, with stage indices 0 to log2(N)-1, forms a full transform, and the last stage's memory then holds the spectrum in bit-reversed index order. The butterfly arithmetic and the twiddle table contents stay outside the block. The butterfly must return its results a fixed `BF_LAT` cycles after the operands are shown. Once a frame is finished, a neighbouring stage reads the results through the downstream read port.

Top module: `fft_stage_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge, `done` and `op_vld` are low.
- R2: A `start` pulse in idle begins loading. The next N cycles with `in_valid` high store `in_data` at addresses 0 to N-1 in arrival order. Cycles with `in_valid` low are skipped.
- R3: For stage s, the span is N/2^(s+1). Butterfly k (k = 0 to N/2-1) takes x from address a = (k div span)*2*span + (k mod span) and y from address a + span.
- R4: `tw_addr` equals (k mod span)*2^s. It is valid in the same cycle as the operands of butterfly k.
- R5: A word holds the real part in bits [2*DW-1:DW] and the imaginary part in bits [DW-1:0]. The x word is split into `op_xr`/`op_xi` and the y word into `op_yr`/`op_yi`.
- R6: The results present `BF_LAT` cycles after a cycle with `op_vld` high are written back. {`res_ur`,`res_ui`} goes to address a and {`res_vr`,`res_vi`} goes to address a + span.
- R7: Once loading ends, `op_vld` is high for exactly N/2 consecutive cycles, one butterfly per cycle.
- R8: `done` is a single-cycle pulse. It rises N/2 + BF_LAT + 2 clock edges after the edge that stores the last input word.
- R9: A `start` pulse while a frame is in progress has no effect.
- R10: `in_valid` outside the load phase writes nothing.
- R11: While the block is not computing, `dn_data` shows the word at `dn_addr` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only in idle) |
| in_valid | input | 1 | Input sample strobe during loading |
| in_data | input | 2*DW | Packed complex input sample |
| dn_addr | input | log2(N) | Downstream read address |
| dn_data | output | 2*DW | Downstream read data, one cycle latency |
| op_vld | output | 1 | Butterfly operands valid |
| op_xr | output | DW | Real part of x operand |
| op_xi | output | DW | Imaginary part of x operand |
| op_yr | output | DW | Real part of y operand |
| op_yi | output | DW | Imaginary part of y operand |
| tw_addr | output | log2(N)-1 | Twiddle table address |
| res_ur | input | DW | Real part of upper butterfly result |
| res_ui | input | DW | Imaginary part of upper butterfly result |
| res_vr | input | DW | Real part of lower butterfly result |
| res_vi | input | DW | Imaginary part of lower butterfly result |
| done | output | 1 | Frame complete pulse |

## Verification
Some properties are checked on every cycle. The computing state yields an operand cycle on each following edge, no memory port writes while idle, `done` never lasts two cycles, a running frame never re-enters loading, and the two write-back addresses are always one span apart on different words. The bench covers what needs a whole frame to show: pairing, twiddle addresses and in-place write-back. It uses a butterfly model that folds the twiddle address into one result, and checks all four stages of a 16-point transform against a reference. The same scenarios cover load gaps, the `done` latency, and `start` or `in_valid` pulses that come mid-frame or while idle and must leave memory unchanged.

// File: rtl/fft_ctrl_pkg.sv
// Package: shared types of the FFT stage sequencer.
package fft_ctrl_pkg;
    // Phases of one stage's frame.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_CALC  = 2'd2,
        ST_DRAIN = 2'd3
    } stage_state_e;
endpackage

// File: rtl/fft_stage_seq.sv
// fft_stage_seq: phase FSM and address generator of one DIF stage.
// Produces the load address, the operand pair addresses of butterfly k and
// the twiddle address (registered, so it lines up with the operands).
// Assumes N_PTS is a power of two, at least 4, and STAGE < log2(N_PTS).
module fft_stage_seq
    import fft_ctrl_pkg::*;
#(
    parameter int N_PTS = 16,
    parameter int STAGE = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     in_valid,
    input  logic                     pipe_busy,
    output stage_state_e             state,
    output logic                     load_we,
    output logic [$clog2(N_PTS)-1:0] load_addr,
    output logic                     issue,
    output logic [$clog2(N_PTS)-1:0] pair_a,
    output logic [$clog2(N_PTS)-1:0] pair_b,
    output logic [$clog2(N_PTS)-2:0] tw_addr,
    output logic                     done
);
    localparam int AW   = $clog2(N_PTS);
    localparam int KW   = AW - 1;
    localparam int SPAN = N_PTS >> (STAGE + 1);

    stage_state_e  state_q;
    logic [AW-1:0] cnt_q;
    logic [KW-1:0] k_q;
    logic [KW-1:0] j_w;
    logic [KW-1:0] hi_w;
    logic [KW-1:0] tw_q;
    logic          done_q;

    // Split butterfly index into in-group offset and group base.
    always_comb begin
        j_w  = k_q & KW'(SPAN - 1);
        hi_w = k_q & ~KW'(SPAN - 1);
    end

    assign pair_a    = {hi_w, 1'b0} | {1'b0, j_w};
    assign pair_b    = pair_a + AW'(SPAN);
    assign load_we   = (state_q == ST_LOAD) && in_valid;
    assign load_addr = cnt_q;
    assign issue     = (state_q == ST_CALC);
    assign state     = state_q;
    assign tw_addr   = tw_q;
    assign done      = done_q;

    // Phase transitions, load counter, butterfly counter and twiddle register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            k_q     <= '0;
            tw_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_LOAD;
                        cnt_q   <= '0;
                    end
                end
                ST_LOAD: begin
                    if (in_valid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == AW'(N_PTS - 1)) begin
                            state_q <= ST_CALC;
                            k_q     <= '0;
                        end
                    end
                end
                ST_CALC: begin
                    k_q  <= k_q + 1'b1;
                    tw_q <= j_w << STAGE;
                    if (k_q == KW'(N_PTS / 2 - 1)) state_q <= ST_DRAIN;
                end
                default: begin
                    if (!pipe_busy) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    // A running computation never goes back to loading, start or not.
    p_calc_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC && start) |=> (state_q != ST_LOAD && state_q != ST_IDLE));
endmodule

// File: rtl/fft_wb_pipe.sv
// fft_wb_pipe: delay line carrying the pair addresses from issue to write-back.
// Stage 0 lines up with the memory read data (operands valid); stage DEPTH-1
// lines up with the butterfly results. Assumes DEPTH >= 2.
module fft_wb_pipe #(
    parameter int AW    = 4,
    parameter int DEPTH = 3,
    parameter int SPAN  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [AW-1:0] in_a,
    input  logic [AW-1:0] in_b,
    output logic          lead_vld,
    output logic          wr_vld,
    output logic [AW-1:0] wr_a,
    output logic [AW-1:0] wr_b,
    output logic          busy
);
    logic [DEPTH-1:0] vld_q;
    logic [AW-1:0]    a_q [DEPTH];
    logic [AW-1:0]    b_q [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_tap
            if (gi == 0) begin : g_head
                // First tap: capture the addresses issued this cycle.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        vld_q[0] <= 1'b0;
                        a_q[0]   <= '0;
                        b_q[0]   <= '0;
                    end else begin
                        vld_q[0] <= in_vld;
                        a_q[0]   <= in_a;
                        b_q[0]   <= in_b;
                    end
                end
            end else begin : g_body
                // Later taps: shift one step per cycle.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        vld_q[gi] <= 1'b0;
                        a_q[gi]   <= '0;
                        b_q[gi]   <= '0;
                    end else begin
                        vld_q[gi] <= vld_q[gi-1];
                        a_q[gi]   <= a_q[gi-1];
                        b_q[gi]   <= b_q[gi-1];
                    end
                end
            end
        end
    endgenerate

    assign lead_vld = vld_q[0];
    assign wr_vld   = vld_q[DEPTH-1];
    assign wr_a     = a_q[DEPTH-1];
    assign wr_b     = b_q[DEPTH-1];
    assign busy     = |vld_q;

    // Write-back pair stays one span apart (R3, R6).
    p_pair_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |-> (wr_b - wr_a) == AW'(SPAN));
endmodule

// File: rtl/fft_pair_ram.sv
// fft_pair_ram: stage working memory with two read and two write ports.
// Reads are registered (one cycle). Assumes the two write ports never target
// the same word in one cycle.
module fft_pair_ram #(
    parameter int AW = 4,
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_a,
    input  logic [AW-1:0] waddr_a,
    input  logic [WW-1:0] wdata_a,
    input  logic          we_b,
    input  logic [AW-1:0] waddr_b,
    input  logic [WW-1:0] wdata_b,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [WW-1:0] rdata_a,
    output logic [WW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] mem [DEPTH];

    // Store words from both write ports.
    always_ff @(posedge clk) begin
        if (we_a) mem[waddr_a] <= wdata_a;
        if (we_b) mem[waddr_b] <= wdata_b;
    end

    // Registered reads on both read ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_a <= '0;
            rdata_b <= '0;
        end else begin
            rdata_a <= mem[raddr_a];
            rdata_b <= mem[raddr_b];
        end
    end

    // Each butterfly returns into two distinct words (R6).
    p_no_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_a && we_b) |-> (waddr_a != waddr_b));
endmodule

// File: rtl/fft_sel_buf.sv
// fft_sel_buf: select buffers between packed words and real operands.
// Word layout: real part in the upper DW bits, imaginary in the lower DW bits.
module fft_sel_buf #(
    parameter int DW = 16
) (
    input  logic [2*DW-1:0] word_x,
    input  logic [2*DW-1:0] word_y,
    output logic [DW-1:0]   xr,
    output logic [DW-1:0]   xi,
    output logic [DW-1:0]   yr,
    output logic [DW-1:0]   yi,
    input  logic [DW-1:0]   ur,
    input  logic [DW-1:0]   ui,
    input  logic [DW-1:0]   vr,
    input  logic [DW-1:0]   vi,
    output logic [2*DW-1:0] word_u,
    output logic [2*DW-1:0] word_v
);
    // Split two complex words into four real operands.
    always_comb begin
        xr = word_x[2*DW-1:DW];
        xi = word_x[DW-1:0];
        yr = word_y[2*DW-1:DW];
        yi = word_y[DW-1:0];
    end

    // Join four real results into two complex words.
    always_comb begin
        word_u = {ur, ui};
        word_v = {vr, vi};
    end
endmodule

// File: rtl/fft_stage_ctrl.sv
// fft_stage_ctrl: one stage of a radix-2 DIF FFT, minus the butterfly math.
// Loads N packed samples, issues N/2 butterflies (one per cycle), writes the
// results back in place after BF_LAT cycles, then pulses done.
// Assumes the external butterfly has a fixed latency of BF_LAT >= 1 cycles.
module fft_stage_ctrl
    import fft_ctrl_pkg::*;
#(
    parameter int N_PTS  = 16,
    parameter int STAGE  = 0,
    parameter int DW     = 16,
    parameter int BF_LAT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     in_valid,
    input  logic [2*DW-1:0]          in_data,
    input  logic [$clog2(N_PTS)-1:0] dn_addr,
    output logic [2*DW-1:0]          dn_data,
    output logic                     op_vld,
    output logic [DW-1:0]            op_xr,
    output logic [DW-1:0]            op_xi,
    output logic [DW-1:0]            op_yr,
    output logic [DW-1:0]            op_yi,
    output logic [$clog2(N_PTS)-2:0] tw_addr,
    input  logic [DW-1:0]            res_ur,
    input  logic [DW-1:0]            res_ui,
    input  logic [DW-1:0]            res_vr,
    input  logic [DW-1:0]            res_vi,
    output logic                     done
);
    localparam int AW    = $clog2(N_PTS);
    localparam int WW    = 2 * DW;
    localparam int SPAN  = N_PTS >> (STAGE + 1);
    localparam int DEPTH = BF_LAT + 1;

    stage_state_e  state;
    logic          load_we, issue, pipe_busy;
    logic [AW-1:0] load_addr, pair_a, pair_b;
    logic          wr_vld;
    logic [AW-1:0] wr_a, wr_b;
    logic          we_a, we_b;
    logic [AW-1:0] waddr_a, raddr_a;
    logic [WW-1:0] wdata_a;
    logic [WW-1:0] rdata_a, rdata_b;
    logic [WW-1:0] word_u, word_v;

    fft_stage_seq #(.N_PTS(N_PTS), .STAGE(STAGE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .pipe_busy (pipe_busy),
        .state     (state),
        .load_we   (load_we),
        .load_addr (load_addr),
        .issue     (issue),
        .pair_a    (pair_a),
        .pair_b    (pair_b),
        .tw_addr   (tw_addr),
        .done      (done)
    );

    fft_wb_pipe #(.AW(AW), .DEPTH(DEPTH), .SPAN(SPAN)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (issue),
        .in_a     (pair_a),
        .in_b     (pair_b),
        .lead_vld (op_vld),
        .wr_vld   (wr_vld),
        .wr_a     (wr_a),
        .wr_b     (wr_b),
        .busy     (pipe_busy)
    );

    // Port A serves loading and the upper result; port B the lower result.
    always_comb begin
        we_a    = load_we | wr_vld;
        waddr_a = wr_vld ? wr_a : load_addr;
        wdata_a = wr_vld ? word_u : in_data;
        we_b    = wr_vld;
        raddr_a = issue ? pair_a : dn_addr;
    end

    fft_pair_ram #(.AW(AW), .WW(WW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_a    (we_a),
        .waddr_a (waddr_a),
        .wdata_a (wdata_a),
        .we_b    (we_b),
        .waddr_b (wr_b),
        .wdata_b (word_v),
        .raddr_a (raddr_a),
        .raddr_b (pair_b),
        .rdata_a (rdata_a),
        .rdata_b (rdata_b)
    );

    fft_sel_buf #(.DW(DW)) u_sel (
        .word_x (rdata_a),
        .word_y (rdata_b),
        .xr     (op_xr),
        .xi     (op_xi),
        .yr     (op_yr),
        .yi     (op_yi),
        .ur     (res_ur),
        .ui     (res_ui),
        .vr     (res_vr),
        .vi     (res_vi),
        .word_u (word_u),
        .word_v (word_v)
    );

    assign dn_data = rdata_a;

    // Every computing cycle yields an operand cycle next (R7).
    p_issue_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC) |=> op_vld);

    // No memory write while idle (R10).
    p_idle_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !(we_a || we_b));

    // done is a one-cycle pulse (R8).
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/fft_stage_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: four stage instances (s = 0..3) of a 16-point transform share stimulus.
// A butterfly model per instance: u = x + y, v = x - y with the twiddle address
// added into v's imaginary part, so pairing and twiddle addressing both show
// up in the written-back words.
module fft_stage_ctrl_tb;
    localparam int N   = 16;
    localparam int DW  = 16;
    localparam int BFL = 2;
    localparam int NS  = 4;
    localparam int AW  = 4;

    // Vector table: {seed, gaps in in_valid, disturb during compute}
    localparam logic [17:0] VEC [5] = '{
        {16'h0011, 1'b0, 1'b0},
        {16'h00A3, 1'b1, 1'b0},
        {16'h1234, 1'b0, 1'b1},
        {16'hFFF1, 1'b1, 1'b1},
        {16'h0000, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic [2*DW-1:0] in_data = '0;
    logic [AW-1:0] dn_addr = '0;

    logic [NS-1:0]   done_v;
    logic [NS-1:0]   opv_v;
    logic [2*DW-1:0] dn_q [NS];

    int checks = 0;
    int errors = 0;

    logic [2*DW-1:0] frame [N];
    logic [2*DW-1:0] expv [NS][N];

    always #5 clk = ~clk;

    genvar g;
    generate
        for (g = 0; g < NS; g++) begin : g_stage
            logic [DW-1:0] xr, xi, yr, yi;
            logic [AW-2:0] tw;
            logic          ov, dn;
            logic [2*DW-1:0] dd;
            logic [DW-1:0] ur1, ui1, vr1, vi1, ur2, ui2, vr2, vi2;

            fft_stage_ctrl #(.N_PTS(N), .STAGE(g), .DW(DW), .BF_LAT(BFL)) u_dut (
                .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
                .in_data(in_data), .dn_addr(dn_addr), .dn_data(dd),
                .op_vld(ov), .op_xr(xr), .op_xi(xi), .op_yr(yr), .op_yi(yi),
                .tw_addr(tw), .res_ur(ur2), .res_ui(ui2), .res_vr(vr2),
                .res_vi(vi2), .done(dn)
            );

            // Butterfly model with a two-cycle latency.
            always_ff @(posedge clk) begin
                ur1 <= xr + yr;
                ui1 <= xi + yi;
                vr1 <= xr - yr;
                vi1 <= xi - yi + DW'(tw);
                ur2 <= ur1; ui2 <= ui1; vr2 <= vr1; vi2 <= vi1;
            end

            assign done_v[g] = dn;
            assign opv_v[g]  = ov;
            assign dn_q[g]   = dd;
        end
    endgenerate

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2*DW-1:0] sample(input logic [15:0] seed, input int i);
        logic [DW-1:0] re, im;
        re = DW'(seed * (i + 1) * 7 + 3);
        im = seed ^ DW'(i * 13);
        return {re, im};
    endfunction

    // Reference for one stage (R3, R4, R5, R6).
    task automatic build_expect(input logic [15:0] seed);
        for (int i = 0; i < N; i++) frame[i] = sample(seed, i);
        for (int s = 0; s < NS; s++) begin
            int span;
            span = N >> (s + 1);
            for (int i = 0; i < N; i++) expv[s][i] = frame[i];
            for (int k = 0; k < N / 2; k++) begin
                int j, a, b;
                logic [DW-1:0] xr, xi, yr, yi;
                j = k % span;
                a = (k / span) * 2 * span + j;
                b = a + span;
                xr = frame[a][2*DW-1:DW]; xi = frame[a][DW-1:0];
                yr = frame[b][2*DW-1:DW]; yi = frame[b][DW-1:0];
                expv[s][a] = {DW'(xr + yr), DW'(xi + yi)};
                expv[s][b] = {DW'(xr - yr), DW'(xi - yi + DW'(j << s))};
            end
        end
    endtask

    // Read back all words of all stages through the downstream port (R11).
    task automatic readback(input string tag);
        for (int a = 0; a < N; a++) begin
            dn_addr = AW'(a);
            @(negedge clk);
            for (int s = 0; s < NS; s++)
                chk(dn_q[s] === expv[s][a], tag, dn_q[s], expv[s][a]);
        end
    endtask

    // One frame: start, load (optionally with gaps), compute, check timing.
    task automatic run_frame(input logic [15:0] seed, input bit gaps, input bit disturb);
        int i, cyc, lat, nov, first;
        build_expect(seed);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        i = 0; cyc = 0;
        while (i < N) begin
            if (gaps && (cyc % 3 == 1)) begin
                in_valid = 1'b0;
                in_data  = 32'hDEAD_BEEF;
            end else begin
                in_valid = 1'b1;
                in_data  = frame[i];
                i++;
            end
            cyc++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        lat = 0; nov = 0; first = -1;
        while (done_v[0] !== 1'b1 && lat < 100) begin
            if (disturb && lat == 2) begin
                // R9, R10: start and junk sample during compute are ignored
                start = 1'b1; in_valid = 1'b1; in_data = 32'h5A5A_A5A5;
            end else begin
                start = 1'b0; in_valid = 1'b0;
            end
            if (opv_v[0]) begin
                nov++;
                if (first < 0) first = lat;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0; in_valid = 1'b0;
        chk(lat == N / 2 + BFL + 2, "R8 done latency", lat, N / 2 + BFL + 2);
        chk(done_v == '1, "R8 all stages done together", done_v, '1);
        chk(nov == N / 2 && first == 1, "R7 operand cycles", nov, N / 2);
        @(negedge clk);
        chk(done_v == '0, "R8 done one cycle", done_v, 0);
        readback("R3/R4/R5/R6/R2 stage result");
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done_v == '0, "R1 done low in reset", done_v, 0);
        chk(opv_v == '0, "R1 op_vld low in reset", opv_v, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_v == '0 && opv_v == '0, "R1 quiet after reset", {done_v, opv_v}, 0);

        for (int v = 0; v < 5; v++)
            run_frame(VEC[v][17:2], VEC[v][1], VEC[v][0]);

        // R10: in_valid while idle must not touch memory.
        for (int c = 0; c < 6; c++) begin
            in_valid = 1'b1;
            in_data  = 32'hBAD0_0000 | 32'(c);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(done_v == '0 && opv_v == '0, "R10 idle strobes start nothing", {done_v, opv_v}, 0);
        readback("R10 idle in_valid ignored");

        // R1: reset in the middle of loading returns to idle.
        run_frame(16'h0777, 1'b0, 1'b0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        in_valid = 1'b1; in_data = 32'h1111_2222;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        repeat (40) begin
            @(negedge clk);
            chk(done_v == '0 && opv_v == '0, "R1 idle after mid-frame reset", {done_v, opv_v}, 0);
        end
        run_frame(16'h2468, 1'b1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule